// File: doc/BRIEF.md
# Dual Programmable Down-Counter Timer

The block holds two identical timer channels behind a simple APB-style register bus. Each channel owns a down counter that works on either 32 bits or only on its low 16 bits. A prescaler divides the shared timer tick by 1, 16 or 256. Each channel keeps a reload value and a control byte. The control byte picks one of three counting behaviours: wrap to all ones, reload from the stored value, or stop after one pass.

Whenever a channel's counter is found at zero on an enabled tick, the channel raises its raw interrupt flag. The flag stays set until software writes the clear register. The flag, gated by the channel's interrupt enable, gives both the masked status and that channel's interrupt line. The bus and the counters share one clock. A single-cycle `tick_en` strobe marks each timer-clock tick.

Top module: `dual_countdown_timer`

## Requirements
- R1: After reset, each channel reads VALUE = 0xFFFFFFFF, reload = 0, CTRL = 0x20 (stopped, wrapping mode, 16-bit, divide-by-1, interrupt enable set), raw status = 0, and both irq lines are low.
- R2: While CTRL.run (bit 7) is 1, each prescaler step lowers the counter by exactly one. While run is 0, the counter keeps its value whatever `tick_en` does.
- R3: With CTRL.periodic (bit 6) = 1 and CTRL.one_shot (bit 0) = 0, a step that finds the counter at zero sets the raw flag and reloads the counter from the reload value.
- R4: With CTRL.one_shot = 1, whatever the periodic bit holds, a step at zero sets the raw flag once. The counter then stays at zero and raises no further flag until the LOAD register is written.
- R5: With periodic = 0 and one_shot = 0, a step at zero sets the raw flag and wraps the counter to 0xFFFFFFFF (32-bit) or to 0xFFFF in the low half (16-bit).
- R6: With CTRL.size32 (bit 1) = 0, only bits 15:0 count. Zero is detected on bits 15:0 alone, and bits 31:16 never change on a step.
- R7: Register map: paddr[5] selects the channel and paddr[4:2] selects the register: 0 LOAD, 1 VALUE (read only), 2 CTRL, 3 ICLR, 4 RAW, 5 MASKED, 6 BGLOAD. LOAD and BGLOAD both read back the reload value. A LOAD write sets both the counter and the reload value. A BGLOAD write sets only the reload value.
- R8: A write of any data to ICLR clears that channel's raw flag.
- R9: MASKED and irq[ch] equal the raw flag ANDed with CTRL.ien (bit 5).
- R10: CTRL bits 3:2 select the prescale: 00 divides by 1, 01 by 16, 10 by 256, and 11 behaves as divide-by-1. The prescale count restarts on a LOAD write and while the channel is stopped.
- R11: The two channels are independent. Accesses to one channel leave the other's counter and irq unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer-clock tick strobe, one cycle per tick |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 6 | Byte address: bit 5 channel, bits 4:2 register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational while psel is high |
| irq | output | 2 | Per-channel masked interrupt |

## Verification
A write lands on the clock edge of its access phase. Reads are combinational, so the bench samples a register 1 ns after it presents the address, with no edge in between. Each counter step, flag set or reload appears after the very edge on which `tick_en` was high (plus 15 or 255 earlier ticks under division). The bench therefore holds `tick_en` low during every bus access and raises it for an exact number of edges before it reads VALUE, RAW, MASKED or `irq`.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int unsigned CTRL_W   = 8;
  localparam int unsigned PRE_W    = 8;
  localparam int unsigned PRE16_W  = 4;
  localparam logic [7:0]  CTRL_RST = 8'h20;

  typedef enum logic [1:0] {
    PS_DIV1   = 2'b00,
    PS_DIV16  = 2'b01,
    PS_DIV256 = 2'b10,
    PS_RSVD   = 2'b11
  } presc_e;

  typedef struct packed {
    logic   run;
    logic   periodic;
    logic   ien;
    logic   spare;
    presc_e presc;
    logic   size32;
    logic   one_shot;
  } ctrl_t;

  typedef enum logic [2:0] {
    RG_LOAD   = 3'd0,
    RG_VALUE  = 3'd1,
    RG_CTRL   = 3'd2,
    RG_ICLR   = 3'd3,
    RG_RAW    = 3'd4,
    RG_MASKED = 3'd5,
    RG_BGLOAD = 3'd6
  } reg_e;
endpackage

// File: rtl/dct_prescaler.sv
module dct_prescaler
  import dct_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick_en,
  input  logic   run,
  input  logic   restart,
  input  presc_e presc,
  output logic   step
);
  logic [PRE_W-1:0] pcnt_q, pcnt_d;

  always_comb begin
    if (!run || restart)  pcnt_d = '0;
    else if (tick_en)     pcnt_d = pcnt_q + 1'b1;
    else                  pcnt_d = pcnt_q;
  end

  always_comb begin
    case (presc)
      PS_DIV16:  step = run && tick_en && (pcnt_q[PRE16_W-1:0] == {PRE16_W{1'b1}});
      PS_DIV256: step = run && tick_en && (pcnt_q == {PRE_W{1'b1}});
      default:   step = run && tick_en;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/dct_channel.sv
module dct_channel
  import dct_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          wr_load,
  input  logic          wr_bg,
  input  logic          wr_ctrl,
  input  logic          wr_iclr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cnt,
  output logic [DW-1:0] reload,
  output ctrl_t         ctrl,
  output logic          raw
);
  localparam int HW = DW / 2;

  logic [DW-1:0] cnt_q, cnt_d, reload_q, reload_d;
  ctrl_t         ctrl_q, ctrl_d;
  logic          raw_q, raw_d, spent_q, spent_d;
  logic          at_zero, periodic_mode;

  assign at_zero       = ctrl_q.size32 ? (cnt_q == '0) : (cnt_q[HW-1:0] == '0);
  assign periodic_mode = ctrl_q.periodic && !ctrl_q.one_shot;

  always_comb begin
    cnt_d    = cnt_q;
    reload_d = reload_q;
    ctrl_d   = ctrl_q;
    raw_d    = raw_q;
    spent_d  = spent_q && ctrl_q.one_shot;
    if (wr_iclr) raw_d = 1'b0;
    if (wr_ctrl) ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
    if (wr_bg)   reload_d = wdata;
    if (wr_load) begin
      reload_d = wdata;
      cnt_d    = wdata;
      spent_d  = 1'b0;
    end else if (step) begin
      if (at_zero) begin
        if (!(ctrl_q.one_shot && spent_q)) raw_d = 1'b1;
        if (ctrl_q.one_shot)
          spent_d = 1'b1;
        else if (periodic_mode)
          cnt_d = ctrl_q.size32 ? reload_q : {cnt_q[DW-1:HW], reload_q[HW-1:0]};
        else
          cnt_d = ctrl_q.size32 ? '1 : {cnt_q[DW-1:HW], {HW{1'b1}}};
      end else begin
        cnt_d = ctrl_q.size32 ? cnt_q - 1'b1
                              : {cnt_q[DW-1:HW], cnt_q[HW-1:0] - 1'b1};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '1;
      reload_q <= '0;
      ctrl_q   <= ctrl_t'(CTRL_RST);
      raw_q    <= 1'b0;
      spent_q  <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      reload_q <= reload_d;
      ctrl_q   <= ctrl_d;
      raw_q    <= raw_d;
      spent_q  <= spent_d;
    end
  end

  assign cnt    = cnt_q;
  assign reload = reload_q;
  assign ctrl   = ctrl_q;
  assign raw    = raw_q;
endmodule

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer
  import dct_pkg::*;
#(
  parameter  int NCH = 2,
  parameter  int DW  = 32,
  localparam int CHB = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW  = 5 + CHB
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_en,
  input  logic           psel,
  input  logic           penable,
  input  logic           pwrite,
  input  logic [AW-1:0]  paddr,
  input  logic [DW-1:0]  pwdata,
  output logic [DW-1:0]  prdata,
  output logic [NCH-1:0] irq
);
  logic [NCH-1:0][DW-1:0] cnt_vec, reload_vec;
  ctrl_t [NCH-1:0]        ctrl_vec;
  logic [NCH-1:0]         raw_vec, ien_vec, step_vec, wr_load_vec;
  logic [CHB-1:0]         ch_sel;
  reg_e                   reg_sel;
  logic                   aligned, bus_wr;

  assign ch_sel  = paddr[5 +: CHB];
  assign reg_sel = reg_e'(paddr[4:2]);
  assign aligned = (paddr[1:0] == 2'b00);
  assign bus_wr  = psel && penable && pwrite && aligned;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit, wr_bg, wr_ctrl, wr_iclr;
    assign hit            = bus_wr && (int'(ch_sel) == g);
    assign wr_load_vec[g] = hit && (reg_sel == RG_LOAD);
    assign wr_bg          = hit && (reg_sel == RG_BGLOAD);
    assign wr_ctrl        = hit && (reg_sel == RG_CTRL);
    assign wr_iclr        = hit && (reg_sel == RG_ICLR);

    dct_prescaler u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .run     (ctrl_vec[g].run),
      .restart (wr_load_vec[g]),
      .presc   (ctrl_vec[g].presc),
      .step    (step_vec[g])
    );

    dct_channel #(.DW(DW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step_vec[g]),
      .wr_load (wr_load_vec[g]),
      .wr_bg   (wr_bg),
      .wr_ctrl (wr_ctrl),
      .wr_iclr (wr_iclr),
      .wdata   (pwdata),
      .cnt     (cnt_vec[g]),
      .reload  (reload_vec[g]),
      .ctrl    (ctrl_vec[g]),
      .raw     (raw_vec[g])
    );

    assign ien_vec[g] = ctrl_vec[g].ien;
    assign irq[g]     = raw_vec[g] && ien_vec[g];
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite && aligned && (int'(ch_sel) < NCH)) begin
      case (reg_sel)
        RG_LOAD, RG_BGLOAD: prdata = reload_vec[ch_sel];
        RG_VALUE:           prdata = cnt_vec[ch_sel];
        RG_CTRL:            prdata = {{(DW-CTRL_W){1'b0}}, ctrl_vec[ch_sel]};
        RG_RAW:             prdata = {{(DW-1){1'b0}}, raw_vec[ch_sel]};
        RG_MASKED:          prdata = {{(DW-1){1'b0}}, irq[ch_sel]};
        default:            prdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dual_countdown_timer_chk.sv
module dual_countdown_timer_chk #(
  parameter int NCH = 2,
  parameter int DW  = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tick_en,
  input logic [DW-1:0]          pwdata,
  input logic [NCH-1:0]         irq,
  input logic [NCH-1:0][DW-1:0] cnt_vec,
  input logic [NCH-1:0]         raw_vec,
  input logic [NCH-1:0]         ien_vec,
  input logic [NCH-1:0]         step_vec,
  input logic [NCH-1:0]         wr_load_vec
);
  localparam int HW = DW / 2;

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    assert_step_needs_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
      step_vec[g] |-> tick_en);

    assert_hold_without_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_vec[g] && !wr_load_vec[g]) |=> $stable(cnt_vec[g]));

    assert_decrement_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_vec[g] && !wr_load_vec[g] && (cnt_vec[g][HW-1:0] != '0))
        |=> (cnt_vec[g][HW-1:0] == $past(cnt_vec[g][HW-1:0]) - 1'b1));

    assert_load_sets_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_load_vec[g] |=> (cnt_vec[g] == $past(pwdata)));

    assert_raw_set_by_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_vec[g]) |-> $past(step_vec[g]));

    assert_mask_gates_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ien_vec[g] |-> !irq[g]);
  end
endmodule

bind dual_countdown_timer dual_countdown_timer_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_en     (tick_en),
  .pwdata      (pwdata),
  .irq         (irq),
  .cnt_vec     (cnt_vec),
  .raw_vec     (raw_vec),
  .ien_vec     (ien_vec),
  .step_vec    (step_vec),
  .wr_load_vec (wr_load_vec)
);

// File: tb/test_dual_countdown_timer.sv
module test_dual_countdown_timer;
  localparam int CLK_P = 10;
  localparam int R_LOAD = 0, R_VALUE = 1, R_CTRL = 2, R_ICLR = 3,
                 R_RAW = 4, R_MASKED = 5, R_BGLOAD = 6;

  logic        clk, rst_n, tick_en, psel, penable, pwrite;
  logic [5:0]  paddr;
  logic [31:0] pwdata, prdata;
  logic [1:0]  irq;
  int          n_checks, n_fail;
  bit          done;

  dual_countdown_timer i_dual_countdown_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .psel(psel),
    .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .prdata(prdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [5:0] adr(int ch, int idx);
    return 6'((ch << 5) | (idx << 2));
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(int ch, int idx, logic [31:0] d);
    @(negedge clk);
    paddr = adr(ch, idx); pwdata = d; pwrite = 1'b1; psel = 1'b1; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(int ch, int idx, output logic [31:0] d);
    paddr = adr(ch, idx); pwrite = 1'b0; psel = 1'b1;
    #1 d = prdata;
    psel = 1'b0;
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic expect_reg(string req, int ch, int idx, logic [31:0] exp);
    logic [31:0] d;
    rd(ch, idx, d);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    expect_reg("R1 value", 0, R_VALUE, 32'hFFFF_FFFF);
    expect_reg("R1 reload", 0, R_LOAD, 32'h0);
    expect_reg("R1 ctrl", 0, R_CTRL, 32'h20);
    expect_reg("R1 raw", 0, R_RAW, 32'h0);
    expect_reg("R1 ch1 value", 1, R_VALUE, 32'hFFFF_FFFF);
    check("R1 irq", {30'b0, irq}, 32'h0);
  endtask

  task automatic t_periodic;
    wr(0, R_CTRL, 32'hE2);
    wr(0, R_LOAD, 32'd5);
    ticks(5);
    expect_reg("R2 count down", 0, R_VALUE, 32'd0);
    expect_reg("R3 no flag before zero step", 0, R_RAW, 32'd0);
    ticks(1);
    expect_reg("R3 reload", 0, R_VALUE, 32'd5);
    expect_reg("R3 raw set", 0, R_RAW, 32'd1);
    check("R9 irq high", {30'b0, irq}, 32'h1);
    wr(0, R_ICLR, 32'hDEAD_0000);
    expect_reg("R8 clear", 0, R_RAW, 32'd0);
    ticks(6);
    expect_reg("R3 second period", 0, R_RAW, 32'd1);
    expect_reg("R3 second reload", 0, R_VALUE, 32'd5);
  endtask

  task automatic t_one_shot;
    wr(0, R_ICLR, 32'h0);
    wr(0, R_CTRL, 32'hE3);
    wr(0, R_LOAD, 32'd3);
    ticks(4);
    expect_reg("R4 holds zero", 0, R_VALUE, 32'd0);
    expect_reg("R4 raw once", 0, R_RAW, 32'd1);
    wr(0, R_ICLR, 32'h0);
    ticks(5);
    expect_reg("R4 stays halted", 0, R_VALUE, 32'd0);
    expect_reg("R4 no re-flag", 0, R_RAW, 32'd0);
    wr(0, R_LOAD, 32'd2);
    expect_reg("R4 rearm value", 0, R_VALUE, 32'd2);
    ticks(3);
    expect_reg("R4 rearm flag", 0, R_RAW, 32'd1);
  endtask

  task automatic t_free_run;
    wr(0, R_ICLR, 32'h0);
    wr(0, R_CTRL, 32'hA0);
    wr(0, R_LOAD, 32'h1234_0001);
    ticks(1);
    expect_reg("R6 low half only", 0, R_VALUE, 32'h1234_0000);
    expect_reg("R6 upper ignored for zero", 0, R_RAW, 32'd0);
    ticks(1);
    expect_reg("R5 wrap 16", 0, R_VALUE, 32'h1234_FFFF);
    expect_reg("R5 raw 16", 0, R_RAW, 32'd1);
    wr(0, R_ICLR, 32'h0);
    wr(0, R_CTRL, 32'hA2);
    wr(0, R_LOAD, 32'h0);
    ticks(1);
    expect_reg("R5 wrap 32", 0, R_VALUE, 32'hFFFF_FFFF);
    expect_reg("R5 raw 32", 0, R_RAW, 32'd1);
    ticks(1);
    expect_reg("R2 after wrap", 0, R_VALUE, 32'hFFFF_FFFE);
  endtask

  task automatic t_background;
    wr(0, R_ICLR, 32'h0);
    wr(0, R_CTRL, 32'hE2);
    wr(0, R_LOAD, 32'd10);
    ticks(2);
    wr(0, R_BGLOAD, 32'd3);
    expect_reg("R7 bgload keeps count", 0, R_VALUE, 32'd8);
    expect_reg("R7 reload readback", 0, R_LOAD, 32'd3);
    ticks(9);
    expect_reg("R7 new reload used", 0, R_VALUE, 32'd3);
  endtask

  task automatic t_mask;
    wr(0, R_CTRL, 32'hC2);
    wr(0, R_ICLR, 32'h0);
    wr(0, R_LOAD, 32'd1);
    ticks(2);
    expect_reg("R9 raw while masked", 0, R_RAW, 32'd1);
    expect_reg("R9 masked status off", 0, R_MASKED, 32'd0);
    check("R9 irq masked", {30'b0, irq}, 32'h0);
    wr(0, R_CTRL, 32'h62);
    check("R9 irq after enable", {30'b0, irq}, 32'h1);
    expect_reg("R9 masked status on", 0, R_MASKED, 32'd1);
  endtask

  task automatic t_prescale;
    wr(0, R_CTRL, 32'hE6);
    wr(0, R_LOAD, 32'd100);
    ticks(15);
    expect_reg("R10 div16 hold", 0, R_VALUE, 32'd100);
    ticks(1);
    expect_reg("R10 div16 step", 0, R_VALUE, 32'd99);
    wr(0, R_CTRL, 32'hEA);
    wr(0, R_LOAD, 32'd100);
    ticks(255);
    expect_reg("R10 div256 hold", 0, R_VALUE, 32'd100);
    ticks(1);
    expect_reg("R10 div256 step", 0, R_VALUE, 32'd99);
    wr(0, R_CTRL, 32'hEE);
    wr(0, R_LOAD, 32'd100);
    ticks(3);
    expect_reg("R10 code 11 as div1", 0, R_VALUE, 32'd97);
  endtask

  task automatic t_stopped;
    wr(0, R_CTRL, 32'h62);
    wr(0, R_ICLR, 32'h0);
    wr(0, R_LOAD, 32'd50);
    ticks(5);
    expect_reg("R2 stopped holds", 0, R_VALUE, 32'd50);
  endtask

  task automatic t_channel1;
    wr(1, R_CTRL, 32'hE2);
    wr(1, R_LOAD, 32'd2);
    ticks(3);
    expect_reg("R11 ch1 raw", 1, R_RAW, 32'd1);
    check("R11 irq only ch1", {30'b0, irq}, 32'h2);
    expect_reg("R11 ch0 untouched", 0, R_VALUE, 32'd50);
  endtask

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; tick_en = 1'b0; psel = 1'b0; penable = 1'b0;
    pwrite = 1'b0; paddr = '0; pwdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_periodic;
    t_one_shot;
    t_free_run;
    t_background;
    t_mask;
    t_prescale;
    t_stopped;
    t_channel1;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule